// File: doc/BRIEF.md
# I2C Bus Condition Generator

This block drives the open-drain SDA and SCL lines of a simple software-driven serial engine. It creates the bus framing events: start, repeated start and stop. Software controls it through one byte-wide register. That register has two 2-bit pin selectors, three self-clearing request bits and a sticky completion flag.

Each pin has its own selector. A selector can give the pin to the shift engine, to the condition sequencer, to a constant low or to release. The sequencer times every phase with a programmable half-period count. It extends the phases in which SCL is released for as long as another device holds SCL low. A request waits until the sampled bus levels allow it. When the condition is complete, the request bit clears and the completion flag is set.

Top module: `i2c_cond_gen`

Register layout (`ctl_wdata` / `ctl_rdata`): bits [1:0] SDA selector, bits [3:2] SCL selector, bit 4 start request, bit 5 repeated-start request, bit 6 stop request, bit 7 completion flag. Selector codes: 00 serial engine (the pin is pulled low when the engine's level is 0), 01 condition sequencer, 10 forced low, 11 released.

## Requirements
- R1: After reset the register reads 0x00, both selectors are 00, and each pin is pulled low exactly when the engine level for that pin is 0.
- R2: Each pin's drive-low output follows its selector: 00 gives the inverse of the engine level, 01 gives the sequencer's drive, 10 gives 1 and 11 gives 0.
- R3: A start runs only when both selectors are 01. It pulls SDA low one cycle after the request is written. It pulls SCL low after a further `half_cnt` cycles.
- R4: A start request waits, with no change on the pins, while either sampled line is low.
- R5: A repeated start waits while sampled SCL is high. When it runs, it releases SDA and then SCL, waiting a half-period after each. It then pulls SDA low, and one half-period later it pulls SCL low.
- R6: A stop waits while sampled SCL is high. When it runs, it holds SDA low and releases SCL. After a half-period it releases SDA.
- R7: Every half-period that follows an SCL release counts only cycles in which sampled SCL is high.
- R8: When a condition completes, its request bit clears and bit 7 becomes 1. Writing bit 7 as 0 clears the flag.
- R9: A write that carries bit 7 = 1 accepts no request; all request bits read 0 afterwards.
- R10: A write with more than one request bit set clears all three request bits, and nothing starts.
- R11: Writing 0 to an active request bit stops the sequence at once. The pins keep their current drive, and the flag stays 0.
- R12: If a register write falls on the cycle a condition completes, the flag still reads 1 and the request bits read 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Register write strobe |
| ctl_wdata | input | 8 | Register write data |
| ctl_rdata | output | 8 | Register contents |
| ser_sda | input | 1 | Serial engine SDA level |
| ser_scl | input | 1 | Serial engine SCL level |
| sda_in | input | 1 | Sampled SDA pin level |
| scl_in | input | 1 | Sampled SCL pin level |
| half_cnt | input | HW | Half-period length in cycles |
| sda_lo | output | 1 | SDA drive-low enable |
| scl_lo | output | 1 | SCL drive-low enable |

## Verification
Two events can fall in the same cycle: a software register write, and the hardware completing a condition, which sets the flag and clears the request. The bench provokes the collision during a repeated start whose SCL phase is stretched. From the half-period and the stretch length it computes the final edge of the sequence, and it presents a write that clears the flag on exactly that edge. The bench then expects the flag to read 1 and every request bit to read 0.

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          ser_sda,
  input  logic          ser_scl,
  input  logic          sda_in,
  input  logic          scl_in,
  input  logic [HW-1:0] half_cnt,
  output logic          sda_lo,
  output logic          scl_lo
);
  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_HOLD = 3'd1, S_RSDA = 3'd2, S_RSCL = 3'd3, S_PSCL = 3'd4
  } st_t;

  logic [1:0]    sda_sel_q, scl_sel_q;
  logic [2:0]    req_q;
  logic          done_q;
  st_t           st_q;
  logic [1:0]    kind_q;
  logic [HW-1:0] cnt_q;
  logic          gsda_q, gscl_q;

  logic [2:0] wr_req;
  logic       wr_ok, gen_ok, stretch_ok, last, tick_end, complete;

  assign wr_req     = ctl_wdata[6:4];
  assign wr_ok      = ((wr_req & (wr_req - 3'd1)) == 3'd0) && !ctl_wdata[7];
  assign gen_ok     = (sda_sel_q == 2'b01) && (scl_sel_q == 2'b01);
  assign stretch_ok = (st_q == S_RSDA) ? 1'b1 : scl_in;
  assign last       = ({1'b0, cnt_q} + 1'b1) >= {1'b0, half_cnt};
  assign tick_end   = stretch_ok && last;
  assign complete   = req_q[kind_q] && tick_end &&
                      ((st_q == S_HOLD) || (st_q == S_PSCL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_sel_q <= 2'b00;
      scl_sel_q <= 2'b00;
      req_q     <= 3'b000;
      done_q    <= 1'b0;
    end else begin
      if (ctl_we) begin
        sda_sel_q <= ctl_wdata[1:0];
        scl_sel_q <= ctl_wdata[3:2];
        req_q     <= wr_ok ? wr_req : 3'b000;
        done_q    <= ctl_wdata[7];
      end
      if (complete) begin
        req_q  <= 3'b000;
        done_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      kind_q <= 2'd0;
      cnt_q  <= '0;
      gsda_q <= 1'b0;
      gscl_q <= 1'b0;
    end else if (st_q == S_IDLE) begin
      cnt_q <= '0;
      if (gen_ok) begin
        if (req_q[0] && sda_in && scl_in) begin
          gsda_q <= 1'b1;
          kind_q <= 2'd0;
          st_q   <= S_HOLD;
        end else if (req_q[1] && !scl_in) begin
          gsda_q <= 1'b0;
          kind_q <= 2'd1;
          st_q   <= S_RSDA;
        end else if (req_q[2] && !scl_in) begin
          gsda_q <= 1'b1;
          gscl_q <= 1'b0;
          kind_q <= 2'd2;
          st_q   <= S_PSCL;
        end
      end
    end else if (!req_q[kind_q]) begin
      st_q <= S_IDLE;
    end else if (tick_end) begin
      cnt_q <= '0;
      unique case (st_q)
        S_HOLD: begin gscl_q <= 1'b1; st_q <= S_IDLE; end
        S_RSDA: begin gscl_q <= 1'b0; st_q <= S_RSCL; end
        S_RSCL: begin gsda_q <= 1'b1; st_q <= S_HOLD; end
        S_PSCL: begin gsda_q <= 1'b0; st_q <= S_IDLE; end
        default: st_q <= S_IDLE;
      endcase
    end else if (stretch_ok) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  function automatic logic pick(input logic [1:0] sel, input logic ser, input logic gen);
    unique case (sel)
      2'b00:   pick = !ser;
      2'b01:   pick = gen;
      2'b10:   pick = 1'b1;
      default: pick = 1'b0;
    endcase
  endfunction

  assign sda_lo    = pick(sda_sel_q, ser_sda, gsda_q);
  assign scl_lo    = pick(scl_sel_q, ser_scl, gscl_q);
  assign ctl_rdata = {done_q, req_q, scl_sel_q, sda_sel_q};
endmodule

module i2c_cond_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic [2:0] req,
  input logic       done,
  input logic [2:0] st,
  input logic       sda_in,
  input logic       scl_in
);
  a_r4_start_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == 3'd0 && st == 3'd1) |-> $past(sda_in && scl_in));

  a_r5_resume_needs_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == 3'd0 && st != 3'd0 && st != 3'd1) |-> !$past(scl_in));

  a_r8_flag_from_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !$past(ctl_we)) |-> ($past(st) != 3'd0 && $past(req) != 3'd0));

  a_r9_flag_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[7]) |=> (req == 3'd0));

  a_r10_multi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && $countones(ctl_wdata[6:4]) > 1) |=> (req == 3'd0));

  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 3'd0 && req == 3'd0) |=> (st == 3'd0));

  a_r12_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req));
endmodule

bind i2c_cond_gen i2c_cond_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .req(req_q), .done(done_q), .st(st_q), .sda_in(sda_in), .scl_in(scl_in)
);

// File: tb/sim_i2c_cond_gen.sv
module sim_i2c_cond_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 8;

  logic clk = 0, rst_n = 0, ctl_we = 0, ser_sda = 1, ser_scl = 1, ext_hold = 0;
  logic [7:0] ctl_wdata = 0, ctl_rdata;
  logic [HW-1:0] half_cnt = 1;
  logic sda_lo, scl_lo, sda_in, scl_in;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_in = ~sda_lo;
  assign scl_in = ~scl_lo & ~ext_hold;

  i2c_cond_gen #(.HW(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .ser_sda(ser_sda), .ser_scl(ser_scl),
    .sda_in(sda_in), .scl_in(scl_in), .half_cnt(half_cnt),
    .sda_lo(sda_lo), .scl_lo(scl_lo));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); ctl_we = 1; ctl_wdata = d;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic idle_check(input string tag, input int n, input logic esda,
                            input logic escl, input logic [7:0] ereg);
    repeat (n) @(negedge clk);
    chk({tag, " sda"}, {7'b0, sda_lo}, {7'b0, esda});
    chk({tag, " scl"}, {7'b0, scl_lo}, {7'b0, escl});
    chk({tag, " reg"}, ctl_rdata, ereg);
  endtask

  // kind 0 start (R3), 1 repeated start (R5), 2 stop (R6); S = stretch cycles (R7)
  task automatic run_cond(input int kind, input int h, input int s, input bit collide);
    int nn, endk, lo, hi;
    logic esda, escl;
    half_cnt = h[HW-1:0];
    nn   = (kind == 1) ? 3 : 1;
    endk = 1 + nn * h + s;
    lo   = (kind == 1) ? 2 + h : 2;
    hi   = lo + s - 1;
    wr(kind == 0 ? 8'h15 : kind == 1 ? 8'h25 : 8'h45);
    for (int k = 1; k <= endk; k++) begin
      ext_hold = (kind != 0) && (k >= lo) && (k <= hi);
      if (collide && k == endk) begin ctl_we = 1; ctl_wdata = 8'h05; end
      @(negedge clk);
      ctl_we = 0;
      case (kind)
        0: begin esda = 1; escl = (k >= 1 + h); end
        1: begin esda = (k >= 1 + 2*h + s); escl = (k < 1 + h) || (k >= endk); end
        default: begin esda = (k < endk); escl = 0; end
      endcase
      chk($sformatf("R3/R5/R6/R7 kind%0d h%0d k%0d sda", kind, h, k), {7'b0, sda_lo}, {7'b0, esda});
      chk($sformatf("R3/R5/R6/R7 kind%0d h%0d k%0d scl", kind, h, k), {7'b0, scl_lo}, {7'b0, escl});
      chk($sformatf("R8 kind%0d h%0d k%0d flag", kind, h, k), {7'b0, ctl_rdata[7]}, {7'b0, k >= endk});
    end
    ext_hold = 0;
    chk(collide ? "R12 collision result" : "R8 self-clear", ctl_rdata, 8'h85);
    wr(8'h05);
    chk("R8 flag cleared by write", ctl_rdata, 8'h05);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    ser_sda = 0;
    #1 chk("R1 reset reg", ctl_rdata, 8'h00);
    chk("R1 reset sda follows engine", {7'b0, sda_lo}, 8'h01);
    chk("R1 reset scl follows engine", {7'b0, scl_lo}, 8'h00);
    rst_n = 1;
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 2; v++) begin
        logic [1:0] sl = s[1:0];
        logic e;
        wr({4'b0, sl, sl});
        ser_sda = v[0]; ser_scl = ~v[0];
        #1;
        e = (sl == 0) ? ~v[0] : (sl == 2);
        chk($sformatf("R2 sda sel%0d v%0d", s, v), {7'b0, sda_lo}, {7'b0, e});
        e = (sl == 0) ? v[0] : (sl == 2);
        chk($sformatf("R2 scl sel%0d v%0d", s, v), {7'b0, scl_lo}, {7'b0, e});
      end
    ser_sda = 1; ser_scl = 1;
    wr(8'h05);
    for (int h = 1; h <= 4; h++) begin
      run_cond(0, h, 0, 0);
      run_cond(1, h, h - 1, h == 3);
      run_cond(2, h, (h % 2) * 2, 0);
    end
    half_cnt = 2;
    wr(8'h25); idle_check("R5 restart waits on high scl", 4, 0, 0, 8'h25); wr(8'h05);
    wr(8'h45); idle_check("R6 stop waits on high scl", 4, 0, 0, 8'h45); wr(8'h05);
    run_cond(0, 2, 0, 0);
    wr(8'h15); idle_check("R4 start waits on low scl", 4, 1, 1, 8'h15); wr(8'h05);
    wr(8'h85); chk("R8 flag is writable", ctl_rdata, 8'h85);
    wr(8'hC5); idle_check("R9 request ignored with flag", 4, 1, 1, 8'h85); wr(8'h05);
    wr(8'h65); idle_check("R10 multiple requests cleared", 4, 1, 1, 8'h05);
    run_cond(2, 1, 0, 0);
    wr(8'h14); idle_check("R3 start needs both selectors", 4, 0, 0, 8'h14); wr(8'h05);
    half_cnt = 4;
    wr(8'h15);
    @(negedge clk); @(negedge clk);
    wr(8'h05);
    idle_check("R11 abort freezes pins", 6, 1, 0, 8'h05);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule